// File: doc/BRIEF.md
# Fax Line Code Framer

This block sits behind a run-length coder for two-level fax images and wraps each scan line's code bits in the framing a fax stream needs. Every line opens with a 12-bit end-of-line marker. An optional line-skip flag bit follows the marker. The line's code bits come next. Zero fill is appended when the line is shorter than a programmed minimum, and optional zero padding brings the line to a byte boundary. After the programmed number of lines, the block sends a page terminator made of repeated end-of-line markers. It then flushes the last partial byte and raises a one-cycle done pulse.

Code bits arrive one per beat on a valid/ready port. Each beat carries a last-of-line flag and an all-white flag; the all-white flag is read only on the first beat of a line. Framed output leaves as bytes on a valid/ready port. A start pulse captures the configuration inputs and begins a page. Start is ignored while a page is in progress.

Top module: `fax_line_framer`

## Requirements
- R1: Each line begins with an end-of-line marker of eleven 0 bits followed by one 1 bit.
- R2: The line length counts the bits after the marker: the skip bit, if present, plus the code bits. When this length is below the minimum `cfg_min_bits` (0 to 65535), 0 bits are appended until the length equals the minimum. When the length already meets the minimum, nothing is appended.
- R3: With `cfg_skip_en` = 1, exactly one skip bit follows every line's marker: 1 for an all-white line, 0 otherwise. With `cfg_skip_en` = 0, no skip bit is sent and `in_white` has no effect.
- R4: In skip mode, the code bits of an all-white line are accepted and discarded. The line is then filled with 0 bits until its length, counting the skip bit, reaches floor(`cfg_min_bits`/2).
- R5: In skip mode, for a line that is not all white, the code bits follow the skip bit and the full minimum of R2 applies.
- R6: With `cfg_pad_en` = 1, 0 bits are added after the fill until the total number of bits output so far is a multiple of 8. With `cfg_pad_en` = 0, no padding is added.
- R7: After `cfg_lines` lines, `cfg_rtc_eols` (0 to 255) consecutive end-of-line markers are sent. The stream is then completed with 0 bits up to a byte boundary.
- R8: Bytes are packed MSB first: the earliest bit of each byte is `out_data[7]`.
- R9: `done` pulses high for exactly one cycle per page, after the final byte has been taken. `out_valid` is low in that cycle.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. No bit is lost or duplicated under any stall pattern on either port.
- R11: `in_white` is sampled only on the first beat of a line, and `in_last` ends the line. The values of `in_white` on later beats have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page and capture the configuration (used only when idle) |
| cfg_min_bits | input | 16 | Minimum code bits per line |
| cfg_skip_en | input | 1 | Enable the line-skip flag mode |
| cfg_pad_en | input | 1 | Enable per-line byte padding |
| cfg_rtc_eols | input | 8 | Number of markers in the page terminator |
| cfg_lines | input | 16 | Number of lines in the page |
| in_valid | input | 1 | Code bit beat valid |
| in_ready | output | 1 | Code bit beat accepted |
| in_bit | input | 1 | Code bit |
| in_last | input | 1 | Last code bit of the line |
| in_white | input | 1 | Line is all white (first beat only) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | 8 | Packed framed byte, MSB first |
| done | output | 1 | One-cycle end-of-page pulse |

## Verification
The hardest situation to reach is a stalled output at the moment the framer switches between its internal phases. Examples are the step from fill into padding, the step from the last pad bit into the next marker, and the step into the terminator flush. A lost or duplicated bit at any of these points shifts every later byte. The bench holds `out_ready` low three cycles in four and inserts gaps in the input. It does this on a page with skip mode, padding, an odd minimum and a multi-marker terminator, so the packer fills up while each phase change is pending. The full framed byte stream is then compared with a model built from the requirements. All-white lines also drive the opposite `in_white` value on their later beats, so that reading the flag on any beat but the first would show up as a wrong skip bit.

// File: rtl/lf_pkg.sv
package lf_pkg;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_EOL   = 4'd1,
        S_SKIP  = 4'd2,
        S_DATA  = 4'd3,
        S_FILL  = 4'd4,
        S_PAD   = 4'd5,
        S_RTC   = 4'd6,
        S_FLUSH = 4'd7,
        S_DRAIN = 4'd8
    } lf_state_e;

endpackage

// File: rtl/lf_fill.sv
module lf_fill #(
    parameter int MIN_W = 16,
    localparam int LEN_W = MIN_W + 1
) (
    input  logic [LEN_W-1:0] len,
    input  logic [MIN_W-1:0] min_bits,
    input  logic             halve,
    output logic             need
);
    logic [MIN_W-1:0] target;

    always_comb begin
        target = halve ? (min_bits >> 1) : min_bits;
        need   = len < {1'b0, target};
    end
endmodule

// File: rtl/lf_pack.sv
module lf_pack #(
    parameter int W = 8,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_valid,
    input  logic         bit_val,
    output logic         bit_ready,
    output logic         aligned,
    output logic         empty,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [CW-1:0] cnt;
        logic [W-1:0]  ob;
        logic          ov;
    } pk_t;

    pk_t pk_d, pk_q;

    assign bit_ready = !(pk_q.cnt == LAST && pk_q.ov && !out_ready);
    assign aligned   = pk_q.cnt == '0;
    assign empty     = (pk_q.cnt == '0) && !pk_q.ov;
    assign out_valid = pk_q.ov;
    assign out_data  = pk_q.ob;

    always_comb begin
        pk_d = pk_q;
        if (pk_q.ov && out_ready) begin
            pk_d.ov = 1'b0;
        end
        if (bit_valid && bit_ready) begin
            if (pk_q.cnt == LAST) begin
                pk_d.ob  = {pk_q.sr[W-2:0], bit_val};
                pk_d.ov  = 1'b1;
                pk_d.cnt = '0;
                pk_d.sr  = '0;
            end else begin
                pk_d.sr  = {pk_q.sr[W-2:0], bit_val};
                pk_d.cnt = pk_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/lf_seq.sv
module lf_seq
    import lf_pkg::*;
#(
    parameter int MIN_W   = 16,
    parameter int LINES_W = 16,
    parameter int RTC_W   = 8,
    parameter int EOL_W   = 12,
    localparam int LEN_W  = MIN_W + 1,
    localparam int EOLC_W = $clog2(EOL_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [MIN_W-1:0]   cfg_min_bits,
    input  logic               cfg_skip_en,
    input  logic               cfg_pad_en,
    input  logic [RTC_W-1:0]   cfg_rtc_eols,
    input  logic [LINES_W-1:0] cfg_lines,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_bit,
    input  logic               in_last,
    input  logic               in_white,
    output logic               bit_valid,
    output logic               bit_val,
    input  logic               bit_ready,
    input  logic               aligned,
    input  logic               empty,
    output logic               done
);
    localparam logic [EOLC_W-1:0] EOL_END = EOLC_W'(EOL_W - 1);

    typedef struct packed {
        lf_state_e          st;
        logic [EOLC_W-1:0]  eolc;
        logic [LEN_W-1:0]   len;
        logic [LINES_W-1:0] lines;
        logic [RTC_W-1:0]   rtc;
        logic [MIN_W-1:0]   min_bits;
        logic               skip;
        logic               pad;
        logic               white;
        logic               done;
    } sq_t;

    sq_t sq_d, sq_q;

    logic             need_fill;
    logic             eol_one;
    logic [LEN_W-1:0] len_inc;

    lf_fill #(.MIN_W(MIN_W)) u_fill (
        .len      (sq_q.len),
        .min_bits (sq_q.min_bits),
        .halve    (sq_q.skip && sq_q.white),
        .need     (need_fill)
    );

    assign eol_one = sq_q.eolc == EOL_END;
    assign len_inc = (sq_q.len == '1) ? sq_q.len : sq_q.len + 1'b1;
    assign done    = sq_q.done;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        bit_valid = 1'b0;
        bit_val   = 1'b0;
        in_ready  = 1'b0;
        unique case (sq_q.st)
            S_IDLE: begin
                if (start) begin
                    sq_d.min_bits = cfg_min_bits;
                    sq_d.skip     = cfg_skip_en;
                    sq_d.pad      = cfg_pad_en;
                    sq_d.rtc      = cfg_rtc_eols;
                    sq_d.lines    = cfg_lines;
                    sq_d.eolc     = '0;
                    if (cfg_lines != '0)        sq_d.st = S_EOL;
                    else if (cfg_rtc_eols != '0) sq_d.st = S_RTC;
                    else                         sq_d.st = S_FLUSH;
                end
            end
            S_EOL: begin
                bit_valid = 1'b1;
                bit_val   = eol_one;
                if (bit_ready) begin
                    if (eol_one) begin
                        sq_d.eolc  = '0;
                        sq_d.white = 1'b0;
                        sq_d.len   = '0;
                        sq_d.st    = sq_q.skip ? S_SKIP : S_DATA;
                    end else begin
                        sq_d.eolc = sq_q.eolc + 1'b1;
                    end
                end
            end
            S_SKIP: begin
                bit_valid = in_valid;
                bit_val   = in_white;
                if (in_valid && bit_ready) begin
                    sq_d.white = in_white;
                    sq_d.len   = LEN_W'(1);
                    sq_d.st    = S_DATA;
                end
            end
            S_DATA: begin
                if (sq_q.skip && sq_q.white) begin
                    in_ready = 1'b1;
                    if (in_valid && in_last) sq_d.st = S_FILL;
                end else begin
                    bit_valid = in_valid;
                    bit_val   = in_bit;
                    in_ready  = bit_ready;
                    if (in_valid && bit_ready) begin
                        sq_d.len = len_inc;
                        if (in_last) sq_d.st = S_FILL;
                    end
                end
            end
            S_FILL: begin
                if (need_fill) begin
                    bit_valid = 1'b1;
                    if (bit_ready) sq_d.len = len_inc;
                end else begin
                    sq_d.st = S_PAD;
                end
            end
            S_PAD: begin
                if (sq_q.pad && !aligned) begin
                    bit_valid = 1'b1;
                end else begin
                    sq_d.lines = sq_q.lines - 1'b1;
                    sq_d.eolc  = '0;
                    if (sq_q.lines != LINES_W'(1)) sq_d.st = S_EOL;
                    else if (sq_q.rtc != '0)       sq_d.st = S_RTC;
                    else                           sq_d.st = S_FLUSH;
                end
            end
            S_RTC: begin
                bit_valid = 1'b1;
                bit_val   = eol_one;
                if (bit_ready) begin
                    if (eol_one) begin
                        sq_d.eolc = '0;
                        sq_d.rtc  = sq_q.rtc - 1'b1;
                        if (sq_q.rtc == RTC_W'(1)) sq_d.st = S_FLUSH;
                    end else begin
                        sq_d.eolc = sq_q.eolc + 1'b1;
                    end
                end
            end
            S_FLUSH: begin
                if (!aligned) bit_valid = 1'b1;
                else          sq_d.st = S_DRAIN;
            end
            S_DRAIN: begin
                if (empty) begin
                    sq_d.done = 1'b1;
                    sq_d.st   = S_IDLE;
                end
            end
            default: sq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    // Each accepted fill bit lengthens the line by exactly one
    p_fill_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == S_FILL && bit_valid && bit_ready)
            |=> (sq_q.len == $past(sq_q.len) + 1'b1));

    // A padded line hands over to the next marker on a byte boundary
    p_pad_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == S_EOL && $past(sq_q.st) == S_PAD && sq_q.pad) |-> aligned);

    // Terminator flush leaves the packer on a byte boundary
    p_flush_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == S_DRAIN) |-> aligned);
endmodule

// File: rtl/fax_line_framer.sv
module fax_line_framer #(
    parameter int MIN_W   = 16,
    parameter int LINES_W = 16,
    parameter int RTC_W   = 8,
    parameter int EOL_W   = 12,
    parameter int BYTE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [MIN_W-1:0]   cfg_min_bits,
    input  logic               cfg_skip_en,
    input  logic               cfg_pad_en,
    input  logic [RTC_W-1:0]   cfg_rtc_eols,
    input  logic [LINES_W-1:0] cfg_lines,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_bit,
    input  logic               in_last,
    input  logic               in_white,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [BYTE_W-1:0]  out_data,
    output logic               done
);
    logic bit_valid;
    logic bit_val;
    logic bit_ready;
    logic aligned;
    logic empty;

    lf_seq #(
        .MIN_W   (MIN_W),
        .LINES_W (LINES_W),
        .RTC_W   (RTC_W),
        .EOL_W   (EOL_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cfg_min_bits (cfg_min_bits),
        .cfg_skip_en  (cfg_skip_en),
        .cfg_pad_en   (cfg_pad_en),
        .cfg_rtc_eols (cfg_rtc_eols),
        .cfg_lines    (cfg_lines),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_bit       (in_bit),
        .in_last      (in_last),
        .in_white     (in_white),
        .bit_valid    (bit_valid),
        .bit_val      (bit_val),
        .bit_ready    (bit_ready),
        .aligned      (aligned),
        .empty        (empty),
        .done         (done)
    );

    lf_pack #(.W(BYTE_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_val   (bit_val),
        .bit_ready (bit_ready),
        .aligned   (aligned),
        .empty     (empty),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);
endmodule

// File: tb/fax_line_framer_tb.sv
module fax_line_framer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] cfg_min_bits;
    logic        cfg_skip_en;
    logic        cfg_pad_en;
    logic [7:0]  cfg_rtc_eols;
    logic [15:0] cfg_lines;
    logic        in_valid;
    logic        in_ready;
    logic        in_bit;
    logic        in_last;
    logic        in_white;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_data;
    logic        done;

    always #10 clk = ~clk;

    fax_line_framer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_min_bits(cfg_min_bits), .cfg_skip_en(cfg_skip_en),
        .cfg_pad_en(cfg_pad_en), .cfg_rtc_eols(cfg_rtc_eols),
        .cfg_lines(cfg_lines), .in_valid(in_valid), .in_ready(in_ready),
        .in_bit(in_bit), .in_last(in_last), .in_white(in_white),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done)
    );

    int n_vec = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int stall_out = 0;
    int gap_in = 0;
    logic [15:0] lfsr = 16'hACE1;

    int         ln_len[$];
    bit         ln_white[$];
    bit         ln_bits[$];
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];

    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rst_n && done) done_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic add_line(input int n, input bit white, input int seed);
        ln_len.push_back(n);
        ln_white.push_back(white);
        for (int i = 0; i < n; i++) ln_bits.push_back(((i * 37 + seed) % 7) > 3);
    endtask

    task automatic push_eol(ref bit q[$]);
        for (int i = 0; i < 11; i++) q.push_back(1'b0);
        q.push_back(1'b1);
    endtask

    task automatic build_expected();
        bit eb[$];
        int idx = 0;
        int len;
        int tgt;
        for (int l = 0; l < ln_len.size(); l++) begin
            push_eol(eb);
            len = 0;
            if (cfg_skip_en) begin
                eb.push_back(ln_white[l]);
                len = 1;
            end
            for (int b = 0; b < ln_len[l]; b++) begin
                if (!(cfg_skip_en && ln_white[l])) begin
                    eb.push_back(ln_bits[idx]);
                    len++;
                end
                idx++;
            end
            tgt = (cfg_skip_en && ln_white[l]) ? int'(cfg_min_bits) / 2 : int'(cfg_min_bits);
            while (len < tgt) begin
                eb.push_back(1'b0);
                len++;
            end
            if (cfg_pad_en) while (eb.size() % 8 != 0) eb.push_back(1'b0);
        end
        for (int r = 0; r < int'(cfg_rtc_eols); r++) push_eol(eb);
        while (eb.size() % 8 != 0) eb.push_back(1'b0);
        for (int i = 0; i < eb.size(); i += 8) begin
            logic [7:0] by;
            for (int k = 0; k < 8; k++) by[7-k] = eb[i+k];
            exp_q.push_back(by);
        end
    endtask

    task automatic drive();
        int idx = 0;
        bit acc;
        for (int l = 0; l < ln_len.size(); l++) begin
            for (int b = 0; b < ln_len[l]; b++) begin
                in_valid = 1'b1;
                in_bit   = ln_bits[idx];
                in_last  = (b == ln_len[l] - 1);
                // R11: flag is meaningful only on the first beat of the line
                in_white = (b == 0) ? ln_white[l] : ~ln_white[l];
                do begin
                    #2 acc = in_ready;
                    @(negedge clk);
                end while (!acc);
                idx++;
                if (gap_in != 0 && lfsr[2]) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic collect(input string req);
        bit fin = 0;
        bit prev_stall = 0;
        logic [7:0] prev_data = '0;
        int cyc = 0;
        while (!fin) begin
            @(negedge clk);
            out_ready = (stall_out != 0) ? (lfsr[1:0] == 2'b00) : 1'b1;
            #2;
            if (prev_stall)
                chk(out_valid && out_data == prev_data, "R10", "stalled byte held",
                    int'(out_data), int'(prev_data));
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) got_q.push_back(out_data);
            if (done) fin = 1;
            cyc++;
            if (cyc > 8000) begin
                chk(1'b0, req, "page never completed", 0, 1);
                fin = 1;
            end
        end
        out_ready = 1'b1;
    endtask

    task automatic run_page(input string req);
        build_expected();
        done_cnt = 0;
        cfg_lines = 16'(ln_len.size());
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            drive();
            collect(req);
        join
        repeat (6) @(negedge clk);
        chk(got_q.size() == exp_q.size(), req, "byte count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] === exp_q[i], req, $sformatf("byte %0d", i),
                int'(got_q[i]), int'(exp_q[i]));
        chk(done_cnt == 1, "R9", "done pulses per page", done_cnt, 1);
    endtask

    task automatic clear_page();
        ln_len.delete();
        ln_white.delete();
        ln_bits.delete();
        exp_q.delete();
        got_q.delete();
    endtask

    // R1 R8 R7: plain lines, two-marker terminator; white flag ignored (R3)
    task automatic t_basic();
        cfg_min_bits = 16'd0; cfg_skip_en = 0; cfg_pad_en = 0; cfg_rtc_eols = 8'd2;
        stall_out = 0; gap_in = 0;
        add_line(5, 1'b1, 3);
        add_line(9, 1'b0, 11);
        run_page("R1");
        chk(got_q.size() > 1 && got_q[0] == 8'h00, "R8", "first byte of marker",
            int'(got_q[0]), 0);
        chk(got_q.size() > 1 && got_q[1][7:4] == 4'b0001, "R8", "marker tail in MSBs",
            int'(got_q[1][7:4]), 1);
        clear_page();
    endtask

    // R2: fill to minimum, no fill when already long enough
    task automatic t_minfill();
        cfg_min_bits = 16'd40; cfg_skip_en = 0; cfg_pad_en = 0; cfg_rtc_eols = 8'd1;
        stall_out = 0; gap_in = 1;
        add_line(10, 1'b0, 1);
        add_line(40, 1'b0, 2);
        add_line(50, 1'b0, 5);
        run_page("R2");
        clear_page();
    endtask

    // R3 R4 R5 R11: skip mode with white and non-white lines
    task automatic t_skip();
        cfg_min_bits = 16'd30; cfg_skip_en = 1; cfg_pad_en = 0; cfg_rtc_eols = 8'd2;
        stall_out = 0; gap_in = 1;
        add_line(8, 1'b1, 4);
        add_line(6, 1'b0, 9);
        add_line(20, 1'b1, 6);
        add_line(35, 1'b0, 2);
        run_page("R4");
        clear_page();
    endtask

    // R6: byte padding of each line
    task automatic t_pad();
        cfg_min_bits = 16'd13; cfg_skip_en = 0; cfg_pad_en = 1; cfg_rtc_eols = 8'd1;
        stall_out = 0; gap_in = 0;
        add_line(3, 1'b0, 7);
        add_line(17, 1'b0, 8);
        run_page("R6");
        clear_page();
    endtask

    // R10 R5 R4: heavy output stall, odd minimum halved, padding, long terminator
    task automatic t_stall();
        cfg_min_bits = 16'd31; cfg_skip_en = 1; cfg_pad_en = 1; cfg_rtc_eols = 8'd3;
        stall_out = 1; gap_in = 1;
        add_line(12, 1'b0, 3);
        add_line(9, 1'b1, 5);
        add_line(40, 1'b0, 12);
        add_line(1, 1'b1, 2);
        run_page("R10");
        clear_page();
    endtask

    // R7: empty terminator, flush of a partial byte
    task automatic t_norf();
        cfg_min_bits = 16'd0; cfg_skip_en = 0; cfg_pad_en = 0; cfg_rtc_eols = 8'd0;
        stall_out = 0; gap_in = 0;
        add_line(5, 1'b0, 10);
        run_page("R7");
        clear_page();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL R9 watchdog: actual 0 expected 1 completed run");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
        in_last = 1'b0; in_white = 1'b0; out_ready = 1'b1;
        cfg_min_bits = '0; cfg_skip_en = 0; cfg_pad_en = 0;
        cfg_rtc_eols = '0; cfg_lines = '0;
        repeat (3) @(negedge clk);
        #2;
        chk(out_valid == 1'b0, "R10", "reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b0, "R11", "reset in_ready", int'(in_ready), 0);
        chk(done == 1'b0, "R9", "reset done", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        t_basic();
        t_minfill();
        t_skip();
        t_pad();
        t_stall();
        t_norf();
        finish_run();
    end
endmodule